// File: doc/BRIEF.md
# Congestion-Responsive Injection Rate Meter

This block sits on the transmit side of an end system and decides when each outgoing packet may enter the fabric. It holds a token bucket counted in 1/256-byte units. Every clock cycle the bucket gains the current rate value, and the bucket is capped at a configured burst size. A packet is granted only when the bucket covers its whole length. The length is then removed in the cycle of the transfer.

The refill rate is not fixed. Each backward congestion notification pulse cuts the rate by a configured step, and the rate never goes below a configured floor. A quiet counter measures the cycles that pass without a notification. Each time the counter reaches its configured limit, the rate rises by a configured step, up to the provisioned ceiling. The rate is expressed in bytes per 256 cycles, so a rate of 256 means one byte per cycle. Software policy, message parsing and packet storage belong to the surrounding logic.

The request side is a valid/ready interface. The sender raises `req_valid` with the packet length on `req_len` and holds both unchanged until `req_ready` is high at a rising edge. That edge is the transfer. `req_ready` is a combinational function of the bucket level and `req_len` and does not depend on `req_valid`. A sender can therefore back off, or change the length, only while no transfer has taken place.

Top module: `inj_rate_meter`

## Requirements
- R1: `req_ready` is high exactly when the bucket holds at least `req_len`*256 units; a transfer happens on a rising edge where `req_valid` and `req_ready` are both high.
- R2: On a transfer edge the bucket loses `req_len`*256 units and gains the current rate. On every other edge it gains only the rate.
- R3: The bucket never holds more than `cfg_burst`*256 units. A length above `cfg_burst` is therefore never granted, and a length of zero is always granted.
- R4: A notification pulse sampled at a rising edge lowers `rate_now` by `cfg_step_down` at that edge and restarts the quiet counter.
- R5: `rate_now` never falls below `cfg_floor`; a cut that would go lower leaves it at `cfg_floor` (configuration assumes `cfg_floor` <= `cfg_ceiling`).
- R6: After `cfg_quiet` consecutive edges without a notification, `rate_now` rises by `cfg_step_up` and the quiet count starts again. The rate does not rise before then.
- R7: `rate_now` never exceeds `cfg_ceiling`. While `rst_n` is low (synchronous, active low), the rate loads `cfg_ceiling` and the bucket loads `cfg_burst`*256.
- R8: When a notification arrives on the same edge on which a rise is due, only the cut is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Packet waiting to be injected |
| req_len | input | LEN_W | Packet length in bytes |
| req_ready | output | 1 | Bucket covers the requested length |
| note_pulse | input | 1 | One-cycle backward congestion notification |
| cfg_ceiling | input | RATE_W | Provisioned maximum rate, bytes per 256 cycles |
| cfg_floor | input | RATE_W | Minimum rate |
| cfg_step_down | input | RATE_W | Rate cut per notification |
| cfg_step_up | input | RATE_W | Rate rise per quiet period |
| cfg_quiet | input | QUIET_W | Quiet period length in cycles |
| cfg_burst | input | LEN_W | Bucket capacity in bytes |
| rate_now | output | RATE_W | Current refill rate |

## Verification
The embedded assertions check the invariants on every cycle. These are: the rate stays between floor and ceiling, the bucket stays under its cap, a notification never lets the rate rise, no rise happens before the quiet period ends, and a transfer lowers the bucket by the length. Only the bench scenarios can show the exact values. These include the rate after a sequence of cuts and rises, the cycle on which a waiting packet becomes grantable, clamping at the floor, the reduction winning over a rise due on the same edge, and the refusal of an oversized length.

// File: rtl/inj_meter_pkg.sv
package inj_meter_pkg;
  // tokens carry this many fractional bits (rate is bytes per 2**FRAC_BITS cycles)
  localparam int FRAC_BITS = 8;

  typedef enum logic [1:0] {
    ACT_HOLD  = 2'd0,
    ACT_CUT   = 2'd1,
    ACT_RAISE = 2'd2
  } rate_act_e;
endpackage

// File: rtl/inj_rate_ctrl.sv
module inj_rate_ctrl
  import inj_meter_pkg::*;
#(
  parameter int RATE_W  = 16,
  parameter int QUIET_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              note_i,
  input  logic [RATE_W-1:0] ceil_i,
  input  logic [RATE_W-1:0] floor_i,
  input  logic [RATE_W-1:0] down_i,
  input  logic [RATE_W-1:0] up_i,
  input  logic [QUIET_W-1:0] quiet_i,
  output logic [RATE_W-1:0] rate_o
);
  localparam int WR = RATE_W + 1;
  localparam int WQ = QUIET_W + 1;

  logic [RATE_W-1:0]  rate_q, rate_n;
  logic [QUIET_W-1:0] quiet_q;
  logic [WQ-1:0]      quiet_inc;
  logic               quiet_done;
  rate_act_e          act;
  logic [WR-1:0]      cand, lifted;

  assign quiet_inc  = {1'b0, quiet_q} + WQ'(1);
  assign quiet_done = quiet_inc >= {1'b0, quiet_i};

  // a notification outranks a due rise
  always_comb begin
    if (note_i)          act = ACT_CUT;
    else if (quiet_done) act = ACT_RAISE;
    else                 act = ACT_HOLD;
  end

  always_comb begin
    unique case (act)
      ACT_CUT:   cand = (rate_q >= down_i) ? WR'(rate_q - down_i) : '0;
      ACT_RAISE: cand = {1'b0, rate_q} + {1'b0, up_i};
      default:   cand = {1'b0, rate_q};
    endcase
    lifted = (cand < {1'b0, floor_i}) ? {1'b0, floor_i} : cand;
    rate_n = (lifted > {1'b0, ceil_i}) ? ceil_i : lifted[RATE_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rate_q  <= ceil_i;
      quiet_q <= '0;
    end else begin
      rate_q  <= rate_n;
      quiet_q <= (act == ACT_HOLD) ? quiet_inc[QUIET_W-1:0] : '0;
    end
  end

  assign rate_o = rate_q;

  a_r7_rate_ceiling: assert property (@(posedge clk) disable iff (!rst_n)
    rate_q <= ceil_i);
  a_r5_rate_floor: assert property (@(posedge clk) disable iff (!rst_n)
    rate_q >= floor_i);
  a_r4_note_no_rise: assert property (@(posedge clk) disable iff (!rst_n)
    note_i |=> rate_q <= $past(rate_q));
  a_r6_no_early_rise: assert property (@(posedge clk) disable iff (!rst_n)
    (!note_i && !quiet_done) |=> rate_q <= $past(rate_q));
endmodule

// File: rtl/inj_token_bucket.sv
module inj_token_bucket
  import inj_meter_pkg::*;
#(
  parameter int LEN_W  = 12,
  parameter int RATE_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              valid_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic [LEN_W-1:0]  burst_i,
  input  logic [RATE_W-1:0] rate_i,
  output logic              ready_o
);
  localparam int BASE_W = LEN_W + FRAC_BITS;
  localparam int TOK_W  = ((BASE_W > RATE_W) ? BASE_W : RATE_W) + 1;

  logic [TOK_W-1:0] tok_q, tok_n, need, cap, after, sum;
  logic             fire;

  assign need    = TOK_W'({len_i, {FRAC_BITS{1'b0}}});
  assign cap     = TOK_W'({burst_i, {FRAC_BITS{1'b0}}});
  assign ready_o = tok_q >= need;
  assign fire    = valid_i && ready_o;

  always_comb begin
    after = fire ? (tok_q - need) : tok_q;
    sum   = after + TOK_W'(rate_i);
    tok_n = (sum > cap) ? cap : sum;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) tok_q <= cap;
    else        tok_q <= tok_n;
  end

  a_r3_bucket_cap: assert property (@(posedge clk) disable iff (!rst_n)
    tok_q <= cap);
  a_r2_fire_debits: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> tok_q <= $past(tok_q) - $past(need) + TOK_W'($past(rate_i)));
endmodule

// File: rtl/inj_rate_meter.sv
module inj_rate_meter #(
  parameter int LEN_W   = 12,
  parameter int RATE_W  = 16,
  parameter int QUIET_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic [LEN_W-1:0]   req_len,
  output logic               req_ready,
  input  logic               note_pulse,
  input  logic [RATE_W-1:0]  cfg_ceiling,
  input  logic [RATE_W-1:0]  cfg_floor,
  input  logic [RATE_W-1:0]  cfg_step_down,
  input  logic [RATE_W-1:0]  cfg_step_up,
  input  logic [QUIET_W-1:0] cfg_quiet,
  input  logic [LEN_W-1:0]   cfg_burst,
  output logic [RATE_W-1:0]  rate_now
);
  logic [RATE_W-1:0] rate_w;

  inj_rate_ctrl #(.RATE_W(RATE_W), .QUIET_W(QUIET_W)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .note_i  (note_pulse),
    .ceil_i  (cfg_ceiling),
    .floor_i (cfg_floor),
    .down_i  (cfg_step_down),
    .up_i    (cfg_step_up),
    .quiet_i (cfg_quiet),
    .rate_o  (rate_w)
  );

  inj_token_bucket #(.LEN_W(LEN_W), .RATE_W(RATE_W)) u_bucket (
    .clk     (clk),
    .rst_n   (rst_n),
    .valid_i (req_valid),
    .len_i   (req_len),
    .burst_i (cfg_burst),
    .rate_i  (rate_w),
    .ready_o (req_ready)
  );

  assign rate_now = rate_w;

  a_r1_ready_rate_known: assert property (@(posedge clk) disable iff (!rst_n)
    !$isunknown(req_ready));
endmodule

// File: tb/inj_rate_meter_bench.sv
module inj_rate_meter_bench;
  localparam int LEN_W = 12, RATE_W = 16, QUIET_W = 16;

  logic clk = 0, rst_n = 0, req_valid = 0, req_ready, note_pulse = 0;
  logic [LEN_W-1:0]   req_len = '0;
  logic [RATE_W-1:0]  rate_now;
  logic [RATE_W-1:0]  cfg_ceiling = 16'd256, cfg_floor = 16'd64;
  logic [RATE_W-1:0]  cfg_step_down = 16'd100, cfg_step_up = 16'd50;
  logic [QUIET_W-1:0] cfg_quiet = 16'd8;
  logic [LEN_W-1:0]   cfg_burst = 12'd16;
  int total = 0, bad = 0;

  always #5 clk = ~clk;

  inj_rate_meter #(.LEN_W(LEN_W), .RATE_W(RATE_W), .QUIET_W(QUIET_W)) u_inj_rate_meter (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_len(req_len),
    .req_ready(req_ready), .note_pulse(note_pulse), .cfg_ceiling(cfg_ceiling),
    .cfg_floor(cfg_floor), .cfg_step_down(cfg_step_down), .cfg_step_up(cfg_step_up),
    .cfg_quiet(cfg_quiet), .cfg_burst(cfg_burst), .rate_now(rate_now)
  );

  // per entry: pulse once, wait N edges, expect rate (floor 64, ceiling 256, -100/+50, quiet 8)
  localparam int          TB_WAIT[7] = '{0, 3, 7, 8, 16, 40, 0};
  localparam int          TB_EXP[7]  = '{156, 64, 64, 114, 164, 256, 156};
  localparam logic [15:0] TB_TAG[7]  = '{"R4", "R5", "R5", "R6", "R6", "R7", "R4"};

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_all();
    repeat (3) @(negedge clk);
    rst_n = 1;
    check("R7 reset rate", int'(rate_now), 256);
    req_len = 12'd16; #1;
    check("R7 reset bucket full", int'(req_ready), 1);
    // R1 grant and debit
    req_valid = 1; #1;
    check("R1 grant full", int'(req_ready), 1);
    @(negedge clk);                    // transfer: bucket 0 + 1 byte
    req_len = 12'd4; #1;
    check("R1 not covered", int'(req_ready), 0);
    repeat (2) @(negedge clk); #1;     // 3 bytes
    check("R2 refill 3 bytes", int'(req_ready), 0);
    @(negedge clk); #1;                // 4 bytes
    check("R2 refill 4 bytes", int'(req_ready), 1);
    req_valid = 0;
    req_len = 12'd0; #1;
    check("R3 zero length", int'(req_ready), 1);
    repeat (40) @(negedge clk);
    req_len = 12'd17; #1;
    check("R3 over burst", int'(req_ready), 0);
    req_len = 12'd16; req_valid = 1; #1;
    check("R3 full burst", int'(req_ready), 1);
    @(negedge clk);                    // capped 16 bytes spent, 1 byte back
    req_valid = 0; req_len = 12'd2; #1;
    check("R3 cap held", int'(req_ready), 0);
    // rate vector table
    for (int i = 0; i < 7; i++) begin
      note_pulse = 1;
      @(negedge clk);
      note_pulse = 0;
      repeat (TB_WAIT[i]) @(negedge clk);
      check($sformatf("%s table %0d", TB_TAG[i], i), int'(rate_now), TB_EXP[i]);
    end
    // R6 no rise one edge early, then R8 cut beats due rise
    repeat (7) @(negedge clk);
    check("R6 before quiet", int'(rate_now), 156);
    note_pulse = 1;
    @(negedge clk);
    note_pulse = 0;
    check("R8 cut wins", int'(rate_now), 64);
  endtask

  initial begin
    fork
      run_all();
      begin
        #(1_000_000);
        total++; bad++;
        $display("FAIL watchdog R1 actual=hung expected=done");
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule